// File: doc/BRIEF.md
# Fixed-Point Exponential Pipeline

This block computes y = e^x for a signed fixed-point operand that carries 15 fraction bits, 16 integer bits and a sign bit, and returns the result in the same format. It is a pipeline: it accepts one operand on any clock and produces the matching result a fixed number of cycles later, in the same order.

The operand is split into three fields. The integer field n picks a precomputed e^n. The top six fraction bits p pick a precomputed e^(p/64). The remaining nine fraction bits q, which lie in [0, 2^-6), feed a fourth-order polynomial. Its cubic and quartic coefficients have only a few set bits, so they are built from shifted adds. The three factors are multiplied and rounded to the nearest output code. Operands whose integer field lies outside the supported window skip the datapath result: they give zero or the largest positive code.

Top module: `exp_fx_pipe`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly 4 clock cycles. A new operand may be presented on every cycle, and results leave in the order the operands arrived.
- R2: For an operand whose integer field `in_x[31:15]` (signed) lies in -11..11, and whose exact result does not exceed 0x7FFF_FFFF, `out_y` differs from e^x·2^15 by at most one code.
- R3: An integer field above 11 (x ≥ 12.0) gives `out_y` = 0x7FFF_FFFF with `out_ovf` = 1. So does an operand with integer field 11 whose result rounds above 0x7FFF_FFFF. `out_ovf` is 1 only when `out_y` is 0x7FFF_FFFF.
- R4: An integer field below -11 (x < -11.0) gives `out_y` = 0 with `out_ovf` = 0.
- R5: After a synchronous reset, `out_valid`, `out_y` and `out_ovf` are all 0.
- R6: When `out_valid` is 1, `out_y[31]` is 0, so results are never negative.
- R7: The operand 0 gives exactly 0x0000_8000 (the value 1.0), with `out_ovf` = 0.
- R8: While `out_valid` is 0, `out_y` and `out_ovf` keep the values they last had.
- R9: The most negative code 0x8000_0000 gives 0. The most positive code 0x7FFF_FFFF gives 0x7FFF_FFFF with `out_ovf` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_x | input | 32 | Operand, signed, 15 fraction bits |
| out_valid | output | 1 | Result present this cycle |
| out_y | output | 32 | Result, 15 fraction bits |
| out_ovf | output | 1 | Result saturated high |

## Verification
The bench sweeps the whole operand axis and both clipping regions, and adds dense points around x = 11.09, where the result crosses the top code. Near that edge, a design that compares the wrong bits would saturate one code too early or wrap to a small value. The bench steps exactly across x = -11.0 and x = 12.0, where an off-by-one window would return a garbage product instead of zero or the top code. It also probes x = 0, where any rounding bias in the tables or the polynomial shows up as a code other than 0x8000. Bubbles are inserted between operands so that a result register that does not hold, or a valid bit that slips by a cycle, is seen as soon as it happens.

// File: rtl/exp_fx_pkg.sv
package exp_fx_pkg;

  typedef enum logic [1:0] {
    RC_NORM = 2'd0,
    RC_ZERO = 2'd1,
    RC_SAT  = 2'd2
  } range_cls_e;

  localparam int SERIES_FB = 100;

  // e^(num/den) as a signed value with SERIES_FB fraction bits, Taylor summed
  function automatic logic signed [127:0] exp_series(input int num, input int den, input int terms);
    logic signed [127:0] acc;
    logic signed [127:0] term;
    acc  = 128'sd1 <<< SERIES_FB;
    term = acc;
    for (int i = 1; i <= terms; i++) begin
      term = (term * 128'(num)) / 128'(den * i);
      acc  = acc + term;
    end
    return acc;
  endfunction

  // round a series value to fb fraction bits, nearest
  function automatic logic [63:0] round_series(input logic signed [127:0] v, input int fb);
    logic signed [127:0] r;
    r = (v + (128'sd1 <<< (SERIES_FB - fb - 1))) >>> (SERIES_FB - fb);
    return 64'(r);
  endfunction

endpackage

// File: rtl/exp_range_dec.sv
module exp_range_dec
  import exp_fx_pkg::*;
#(
  parameter int XW    = 32,
  parameter int FW    = 15,
  parameter int PB    = 6,
  parameter int N_LO  = -11,
  parameter int N_HI  = 11,
  parameter int IDX_W = 5
) (
  input  logic [XW-1:0]    x,
  output range_cls_e       cls,
  output logic [IDX_W-1:0] idx,
  output logic [PB-1:0]    pfrac,
  output logic [FW-PB-1:0] qfrac
);
  localparam int IW = XW - FW;

  logic signed [IW-1:0] n;
  logic signed [IW:0]   nrel;

  assign n     = $signed(x[XW-1:FW]);
  assign nrel  = (IW+1)'(n) - (IW+1)'(N_LO);
  assign idx   = IDX_W'(nrel);
  assign pfrac = x[FW-1:FW-PB];
  assign qfrac = x[FW-PB-1:0];

  always_comb begin
    if (n < N_LO)      cls = RC_ZERO;
    else if (n > N_HI) cls = RC_SAT;
    else               cls = RC_NORM;
  end

endmodule

// File: rtl/exp_tbl_rom.sv
module exp_tbl_rom
  import exp_fx_pkg::*;
#(
  parameter int DEPTH   = 23,
  parameter int W       = 48,
  parameter int AW      = 5,
  parameter int FB      = 32,
  parameter int ARG_OFF = -11,
  parameter int ARG_DEN = 1,
  parameter int TERMS   = 60
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  dout
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign mem[i] = W'(round_series(exp_series(i + ARG_OFF, ARG_DEN, TERMS), FB));
  end

  always_ff @(posedge clk) begin
    if (32'(addr) < DEPTH) dout <= mem[addr];
    else                   dout <= '0;
  end

endmodule

// File: rtl/exp_poly.sv
module exp_poly #(
  parameter int FW = 15,
  parameter int QW = 9,
  parameter int PF = 68,
  parameter int PW = 70
) (
  input  logic [QW-1:0] q,
  output logic [PW-1:0] pval
);
  localparam int S1 = PF - FW;
  localparam int S2 = PF - 2*FW - 1;
  localparam int S3 = PF - 3*FW;
  localparam int S4 = PF - 4*FW;
  localparam int C3_TERMS = 6;
  localparam logic [PW-1:0] ONE = PW'(1) << PF;

  logic [2*QW-1:0] q2;
  logic [3*QW-1:0] q3;
  logic [4*QW-1:0] q4;
  logic [PW-1:0]   acc;

  always_comb begin
    q2  = (2*QW)'(q) * (2*QW)'(q);
    q3  = (3*QW)'(q2) * (3*QW)'(q);
    q4  = (4*QW)'(q2) * (4*QW)'(q2);
    acc = ONE + (PW'(q) << S1) + (PW'(q2) << S2);
    // cubic coefficient: set bits at 2^-3, 2^-5 ... 2^-13
    for (int k = 0; k < C3_TERMS; k++) begin
      acc = acc + (PW'(q3) << (S3 - 3 - 2*k));
    end
    // quartic coefficient: set bits at 2^-5, 2^-7, 2^-8
    acc  = acc + (PW'(q4) << (S4 - 5)) + (PW'(q4) << (S4 - 7)) + (PW'(q4) << (S4 - 8));
    pval = acc;
  end

  // R2: factor for the low fraction lies in [1, 1+2^-5)
  always_comb begin
    p_poly_span_r2: assert (pval >= ONE && pval < ONE + (ONE >> 5));
  end

endmodule

// File: rtl/exp_fx_pipe.sv
module exp_fx_pipe
  import exp_fx_pkg::*;
#(
  parameter int XW    = 32,
  parameter int FW    = 15,
  parameter int PB    = 6,
  parameter int N_LO  = -11,
  parameter int N_HI  = 11,
  parameter int EN_FB = 32,
  parameter int MF    = 38
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] in_x,
  output logic          out_valid,
  output logic [XW-1:0] out_y,
  output logic          out_ovf
);
  localparam int IW    = XW - FW;
  localparam int QW    = FW - PB;
  localparam int N_CNT = N_HI - N_LO + 1;
  localparam int IDX_W = $clog2(N_CNT);
  localparam int P_CNT = 1 << PB;
  localparam int PF    = 4*FW + 8;
  localparam int PW    = PF + 2;
  localparam int EN_W  = EN_FB + IW - 1;
  localparam int EP_W  = MF + 2;
  localparam int PM_W  = MF + 2;
  localparam int MX_W  = EP_W + PM_W;
  localparam int M_W   = MF + 3;
  localparam int PR_W  = EN_W + M_W;
  localparam int SH    = EN_FB + MF - FW;
  localparam int YW    = PR_W - SH;
  localparam logic [XW-1:0] YMAX = {1'b0, {(XW-1){1'b1}}};

  range_cls_e       cls_d;
  logic [IDX_W-1:0] idx_d;
  logic [PB-1:0]    p_d;
  logic [QW-1:0]    q_d;

  exp_range_dec #(
    .XW(XW), .FW(FW), .PB(PB), .N_LO(N_LO), .N_HI(N_HI), .IDX_W(IDX_W)
  ) u_dec (
    .x(in_x), .cls(cls_d), .idx(idx_d), .pfrac(p_d), .qfrac(q_d)
  );

  // stage 1: table reads, operand fields registered
  logic [EN_W-1:0] en_s1;
  logic [EP_W-1:0] ep_s1;
  logic [QW-1:0]   q_s1;
  range_cls_e      cls_s1;
  logic            v_s1;

  exp_tbl_rom #(
    .DEPTH(N_CNT), .W(EN_W), .AW(IDX_W), .FB(EN_FB),
    .ARG_OFF(N_LO), .ARG_DEN(1), .TERMS(60)
  ) u_int_rom (
    .clk(clk), .addr(idx_d), .dout(en_s1)
  );

  exp_tbl_rom #(
    .DEPTH(P_CNT), .W(EP_W), .AW(PB), .FB(MF),
    .ARG_OFF(0), .ARG_DEN(P_CNT), .TERMS(30)
  ) u_frac_rom (
    .clk(clk), .addr(p_d), .dout(ep_s1)
  );

  always_ff @(posedge clk) begin
    q_s1   <= q_d;
    cls_s1 <= cls_d;
  end

  // stage 2: polynomial for the low fraction
  logic [PW-1:0]   pv;
  logic [PM_W-1:0] pm_s2;
  logic [EP_W-1:0] ep_s2;
  logic [EN_W-1:0] en_s2;
  range_cls_e      cls_s2;
  logic            v_s2;

  exp_poly #(.FW(FW), .QW(QW), .PF(PF), .PW(PW)) u_poly (.q(q_s1), .pval(pv));

  always_ff @(posedge clk) begin
    pm_s2  <= PM_W'(pv >> (PF - MF));
    ep_s2  <= ep_s1;
    en_s2  <= en_s1;
    cls_s2 <= cls_s1;
  end

  // stage 3: fraction table times polynomial
  logic [M_W-1:0]  m_s3;
  logic [EN_W-1:0] en_s3;
  range_cls_e      cls_s3;
  logic            v_s3;

  always_ff @(posedge clk) begin
    m_s3   <= M_W'((MX_W'(ep_s2) * MX_W'(pm_s2)) >> MF);
    en_s3  <= en_s2;
    cls_s3 <= cls_s2;
  end

  // stage 4: integer factor, rounding, clipping
  logic [PR_W-1:0] prod;
  logic [YW-1:0]   yrnd;
  logic            over;

  always_comb begin
    prod = PR_W'(en_s3) * PR_W'(m_s3);
    yrnd = YW'((prod + (PR_W'(1) << (SH - 1))) >> SH);
    over = (cls_s3 == RC_SAT) || (yrnd > YW'(YMAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_s1      <= 1'b0;
      v_s2      <= 1'b0;
      v_s3      <= 1'b0;
      out_valid <= 1'b0;
      out_y     <= '0;
      out_ovf   <= 1'b0;
    end else begin
      v_s1      <= in_valid;
      v_s2      <= v_s1;
      v_s3      <= v_s2;
      out_valid <= v_s3;
      if (v_s3) begin
        if (cls_s3 == RC_ZERO) begin
          out_y   <= '0;
          out_ovf <= 1'b0;
        end else if (over) begin
          out_y   <= YMAX;
          out_ovf <= 1'b1;
        end else begin
          out_y   <= XW'(yrnd);
          out_ovf <= 1'b0;
        end
      end
    end
  end

  // R1: result valid four cycles after operand valid
  p_lat_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##4 out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##4 !out_valid);
  // R3: flag only with the top code
  p_sat_code_r3: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> out_y == YMAX);
  // R6: never negative
  p_nonneg_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_y[XW-1]);
  // R8: outputs hold across bubbles
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |=> (out_valid || ($stable(out_y) && $stable(out_ovf))));

endmodule

// File: tb/exp_fx_pipe_tb.sv
module exp_fx_pipe_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LAT = 4;
  localparam logic [31:0] YMAX = 32'h7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_x = '0;
  logic        out_valid;
  logic [31:0] out_y;
  logic        out_ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  logic [31:0] stim_x[$];
  bit          stim_v[$];
  logic [31:0] pend[$];
  bit          hist[LAT];
  logic [31:0] last_y = '0;
  logic        last_f = 1'b0;

  always #2.5 clk = ~clk;

  exp_fx_pipe u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_y(out_y), .out_ovf(out_ovf)
  );

  task automatic note(input bit ok, input string line);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", line);
    end
  endtask

  task automatic check_vec(input logic [31:0] x);
    int    sx;
    int    nint;
    real   e;
    real   rv;
    real   d;
    string tg;
    bit    okf;
    sx   = $signed(x);
    nint = sx >>> 15;
    e    = $exp(real'(sx) / 32768.0) * 32768.0;
    tg   = (x == 32'h8000_0000 || x == 32'h7FFF_FFFF) ? "/R9" : "";
    note(!out_y[31], $sformatf("R6 x=%h actual y=%h expected bit31=0", x, out_y));
    if (nint > 11) begin
      note(out_y == YMAX && out_ovf,
           $sformatf("R3%s x=%h actual y=%h ovf=%0b expected y=%h ovf=1", tg, x, out_y, out_ovf, YMAX));
    end else if (nint < -11) begin
      note(out_y == 32'h0 && !out_ovf,
           $sformatf("R4%s x=%h actual y=%h ovf=%0b expected y=0 ovf=0", tg, x, out_y, out_ovf));
    end else if (x == 32'h0) begin
      note(out_y == 32'h0000_8000 && !out_ovf,
           $sformatf("R7 x=%h actual y=%h ovf=%0b expected y=00008000 ovf=0", x, out_y, out_ovf));
    end else begin
      rv = (e > 2147483647.0) ? 2147483647.0 : e;
      d  = real'(out_y) - rv;
      note(d <= 1.0 && d >= -1.0,
           $sformatf("R2 x=%h actual y=%0d expected %f (+-1)", x, out_y, rv));
      okf = 1'b1;
      if (out_ovf && out_y != YMAX) okf = 1'b0;
      if (e > 2147483649.0 && !out_ovf) okf = 1'b0;
      if (e < 2147483645.0 && out_ovf) okf = 1'b0;
      note(okf, $sformatf("R3 x=%h actual y=%h ovf=%0b expected flag for exact %f", x, out_y, out_ovf, e));
    end
  endtask

  task automatic step(input bit v, input logic [31:0] x);
    @(negedge clk);
    note(out_valid === hist[LAT-1],
         $sformatf("R1 actual out_valid=%0b expected %0b", out_valid, hist[LAT-1]));
    if (hist[LAT-1]) begin
      logic [31:0] px;
      px = pend.pop_front();
      if (out_valid === 1'b1) check_vec(px);
      last_y = out_y;
      last_f = out_ovf;
    end else if (out_valid !== 1'b1) begin
      note(out_y === last_y && out_ovf === last_f,
           $sformatf("R8 actual y=%h ovf=%0b expected held y=%h ovf=%0b", out_y, out_ovf, last_y, last_f));
    end
    for (int i = LAT-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0]  = v;
    in_valid = v;
    in_x     = x;
    if (v) pend.push_back(x);
  endtask

  task automatic add(input bit v, input logic [31:0] x);
    stim_v.push_back(v);
    stim_x.push_back(x);
  endtask

  initial begin
    int unsigned lcg;
    int cnt;
    for (int i = 0; i < LAT; i++) hist[i] = 1'b0;
    // R9 and other edges
    add(1, 32'h0000_0000); add(1, 32'h8000_0000); add(1, 32'h7FFF_FFFF);
    add(1, 32'hFFFA_8000); add(1, 32'hFFFA_7FFF); add(1, 32'h0005_8000);
    add(1, 32'h0006_0000); add(1, 32'h0005_FFFF); add(1, 32'hFFFF_FFFF);
    add(1, 32'h0000_0001); add(1, 32'h0000_7FFF); add(1, 32'h0000_8000);
    add(0, 32'h0); add(0, 32'h0); add(0, 32'h0);
    add(1, 32'h0000_0000);
    // full-axis sweep with bubbles
    cnt = 0;
    for (int v = -12 * 32768; v < 409600; v += 1361) begin
      add(1, 32'(v));
      cnt++;
      if (cnt % 5 == 0) add(0, 32'h0);
    end
    // dense points around the top-code crossing
    for (int v = 363390; v <= 363430; v++) add(1, 32'(v));
    // pseudo-random operands
    lcg = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      lcg = lcg * 1664525 + 1013904223;
      add((lcg[3:0] != 4'h0), 32'(int'(lcg % 851968) - 425984));
    end
    for (int i = 0; i < 20; i++) begin
      lcg = lcg * 1664525 + 1013904223;
      add(1, lcg);
    end

    // R5: reset state
    repeat (4) @(negedge clk);
    note(out_valid === 1'b0 && out_y === 32'h0 && out_ovf === 1'b0,
         $sformatf("R5 actual v=%0b y=%h ovf=%0b expected 0/00000000/0", out_valid, out_y, out_ovf));
    rst = 1'b0;

    while (stim_v.size() > 0) begin
      bit v;
      logic [31:0] x;
      v = stim_v.pop_front();
      x = stim_x.pop_front();
      step(v, x);
    end
    for (int i = 0; i < LAT + 3; i++) step(1'b0, 32'h0);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual no completion expected finish within 200000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule